// File: doc/BRIEF.md
# Rate Lock Supervisor

This block watches a clock-recovery loop from the digital side and decides when the loop can be called locked. It counts rising edges of the recovered clock over a fixed window of reference-clock cycles. It then grades each window as in tolerance, harmonic or off-rate. From these grades it steps a three-state machine: frequency acquisition, then phase acquisition, then locked. The loop-select output tells the analog loop which of its two detectors should steer the oscillator.

The rate bus works in two ways. In automatic mode the block drives the rate bus with the code of the rate it is locked to, or was last locked to. In manual mode the bus is an input. The block then locks only when the code on that input is the single supported rate code. The lock and signal-detect flags are the outputs the surrounding system uses for status.

The recovered clock is sampled in the reference domain, so it must run below half the reference frequency. In a real loop it is a divided copy of the serial clock.

Top module: `rate_lock_supervisor`

## Requirements
- R1: During and right after reset, `lock_o`, `sig_det_o` and `loop_sel_o` are low and `rate_out` is 3'b000.
- R2: Each window is `WINDOW` reference cycles long. Within it the block counts rising edges of `rec_clk`. The window is in tolerance when the count is within ±`TOL_PCT`% of `EXPECTED` (default 250, band 245..255). A count 1.2% low is accepted, and counts 2.6% high or 3.6% low are rejected.
- R3: `loop_sel_o` is 0 in frequency acquisition and 1 in phase acquisition or lock. Frequency acquisition moves to phase acquisition on the clock edge that ends an in-tolerance window whose rate is allowed.
- R4: In phase acquisition, `LOCK_WINDOWS` (default 2) back-to-back in-tolerance windows, each with `phase_aligned` high at its last cycle, raise `lock_o`. The flag rises on the edge that ends the last of these windows, three windows after reset when the input is clean.
- R5: An in-tolerance window that ends with `phase_aligned` low clears the aligned-window streak and keeps the block in phase acquisition.
- R6: A window that is out of tolerance, harmonic or at a barred rate sends phase acquisition or lock back to frequency acquisition. `lock_o` and `loop_sel_o` both fall on the edge that ends that window.
- R7: A count near twice `EXPECTED` (±2× the band) or near half of it (±half the band) is a harmonic. It never leads to lock, and the block stays in frequency acquisition.
- R8: In automatic mode (`auto_mode`=1), `rate_oe` is 1. `rate_out` becomes `RATE_CODE` (3'b010) when lock is reached, and it keeps that value after lock is lost.
- R9: In manual mode (`auto_mode`=0), `rate_oe` is 0 and `rate_out` is 3'b000. Lock is allowed only while `rate_in` equals 3'b010. Any other code keeps the block in frequency acquisition, and a change to another code while locked drops lock at the end of the current window.
- R10: `sig_det_o` is high only while locked and the rate is allowed (automatic mode, or `rate_in` = 3'b010). It reacts to `rate_in` in the same cycle, without waiting for a window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state is clocked on it |
| rst | input | 1 | Synchronous active-high reset |
| rec_clk | input | 1 | Recovered (divided) clock to be measured |
| auto_mode | input | 1 | 1 = automatic rate report, 0 = manual rate select |
| rate_in | input | 3 | Programmed rate code in manual mode |
| phase_aligned | input | 1 | Phase detector reports alignment |
| lock_o | output | 1 | Loop locked |
| sig_det_o | output | 1 | Locked at an allowed rate |
| loop_sel_o | output | 1 | 0 = frequency acquisition, 1 = phase acquisition |
| rate_out | output | 3 | Locked or last-locked rate code (automatic mode) |
| rate_oe | output | 1 | Drive enable for the rate bus |

## Verification
Every decision is taken on the single reference edge that closes a window. After reset, window n closes on the n·`WINDOW`-th edge, and the bench counts edges from the release of reset. It samples on the falling edge after edge n·`WINDOW`+1. Lock results are therefore read one window, three windows or more after the stimulus, and the bench also reads the state just before a window closes to show nothing moved early. The one combinational path, from `rate_in` to `sig_det_o`, is read on the falling edge right after the code changes.

// File: rtl/rls_pkg.sv
package rls_pkg;

    typedef enum logic [1:0] {
        ACQ_FREQ   = 2'd0,
        ACQ_PHASE  = 2'd1,
        ACQ_LOCKED = 2'd2
    } acq_state_e;

    typedef enum logic [1:0] {
        WIN_OFF  = 2'd0,
        WIN_GOOD = 2'd1,
        WIN_HARM = 2'd2
    } win_verdict_e;

    typedef struct packed {
        logic         valid;
        win_verdict_e verdict;
    } win_result_t;

    localparam logic [2:0] RATE_NONE = 3'b000;

    // Grade one window count against the target and its harmonics.
    function automatic win_verdict_e judge(input int count, input int target, input int tol_pct);
        int band;
        int hband;
        int dbl;
        int hlf;
        band = (target * tol_pct) / 100;
        if (band < 1) band = 1;
        hband = band / 2;
        if (hband < 1) hband = 1;
        dbl = 2 * target;
        hlf = target / 2;
        if (count >= target - band && count <= target + band)
            return WIN_GOOD;
        if ((count >= dbl - 2 * band && count <= dbl + 2 * band) ||
            (count >= hlf - hband && count <= hlf + hband))
            return WIN_HARM;
        return WIN_OFF;
    endfunction

endpackage

// File: rtl/rls_window_counter.sv
module rls_window_counter
    import rls_pkg::*;
#(
    parameter int WINDOW      = 1000,
    parameter int EXPECTED    = 250,
    parameter int TOL_PCT     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rec_clk,
    output win_result_t result
);

    localparam int WIN_W  = $clog2(WINDOW);
    localparam int CNT_W  = $clog2(WINDOW + 1);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] sync_q;
    logic [WIN_W-1:0]  win_cnt;
    logic [CNT_W-1:0]  edge_cnt;
    logic              edge_pulse;
    logic              win_last;

    // Synchroniser stages plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[PIPE_W-2:0], rec_clk};
    end

    assign edge_pulse = sync_q[PIPE_W-2] & ~sync_q[PIPE_W-1];
    assign win_last   = (win_cnt == WIN_W'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else if (win_last) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else begin
            win_cnt  <= win_cnt + WIN_W'(1);
            edge_cnt <= edge_cnt + CNT_W'(edge_pulse);
        end
    end

    always_comb begin
        result.valid   = win_last;
        result.verdict = judge(int'(edge_cnt) + int'(edge_pulse), EXPECTED, TOL_PCT);
    end

endmodule

// File: rtl/rls_acq_fsm.sv
module rls_acq_fsm
    import rls_pkg::*;
#(
    parameter int         LOCK_WINDOWS = 2,
    parameter logic [2:0] RATE_CODE    = 3'b010
) (
    input  logic        clk,
    input  logic        rst,
    input  win_result_t win,
    input  logic        rate_ok,
    input  logic        phase_aligned,
    output acq_state_e  state,
    output logic [2:0]  rate_hold
);

    localparam int STK_W = $clog2(LOCK_WINDOWS + 1);

    acq_state_e       state_d;
    logic [STK_W-1:0] streak, streak_d;
    logic [2:0]       hold_d;
    logic             qualified;

    assign qualified = (win.verdict == WIN_GOOD) && rate_ok;

    always_comb begin
        state_d  = state;
        streak_d = streak;
        hold_d   = rate_hold;
        case (state)
            ACQ_FREQ: begin
                streak_d = '0;
                if (win.valid && qualified) state_d = ACQ_PHASE;
            end
            ACQ_PHASE: begin
                if (win.valid) begin
                    if (!qualified) begin
                        state_d  = ACQ_FREQ;
                        streak_d = '0;
                    end else if (phase_aligned) begin
                        if (streak == STK_W'(LOCK_WINDOWS - 1)) begin
                            state_d  = ACQ_LOCKED;
                            streak_d = '0;
                            hold_d   = RATE_CODE;
                        end else begin
                            streak_d = streak + STK_W'(1);
                        end
                    end else begin
                        streak_d = '0;
                    end
                end
            end
            ACQ_LOCKED: begin
                if (win.valid && !qualified) state_d = ACQ_FREQ;
            end
            default: state_d = ACQ_FREQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ACQ_FREQ;
            streak    <= '0;
            rate_hold <= RATE_NONE;
        end else begin
            state     <= state_d;
            streak    <= streak_d;
            rate_hold <= hold_d;
        end
    end

endmodule

// File: rtl/rate_lock_supervisor.sv
module rate_lock_supervisor
    import rls_pkg::*;
#(
    parameter int         WINDOW       = 1000,
    parameter int         EXPECTED     = 250,
    parameter int         TOL_PCT      = 2,
    parameter int         LOCK_WINDOWS = 2,
    parameter logic [2:0] RATE_CODE    = 3'b010
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic       rec_clk,
    input  logic       auto_mode,
    input  logic [2:0] rate_in,
    input  logic       phase_aligned,
    output logic       lock_o,
    output logic       sig_det_o,
    output logic       loop_sel_o,
    output logic [2:0] rate_out,
    output logic       rate_oe
);

    win_result_t win_res;
    acq_state_e  acq_state;
    logic [2:0]  rate_hold;
    logic        rate_ok;
    logic        win_end;

    assign rate_ok = auto_mode | (rate_in == RATE_CODE);
    assign win_end = win_res.valid;

    rls_window_counter #(
        .WINDOW   (WINDOW),
        .EXPECTED (EXPECTED),
        .TOL_PCT  (TOL_PCT)
    ) u_counter (
        .clk    (clk_ref),
        .rst    (rst),
        .rec_clk(rec_clk),
        .result (win_res)
    );

    rls_acq_fsm #(
        .LOCK_WINDOWS(LOCK_WINDOWS),
        .RATE_CODE   (RATE_CODE)
    ) u_fsm (
        .clk          (clk_ref),
        .rst          (rst),
        .win          (win_res),
        .rate_ok      (rate_ok),
        .phase_aligned(phase_aligned),
        .state        (acq_state),
        .rate_hold    (rate_hold)
    );

    assign lock_o     = (acq_state == ACQ_LOCKED);
    assign loop_sel_o = (acq_state != ACQ_FREQ);
    assign sig_det_o  = lock_o & rate_ok;
    assign rate_oe    = auto_mode;
    assign rate_out   = auto_mode ? rate_hold : RATE_NONE;

endmodule

// File: rtl/rls_checker.sv
module rls_checker #(
    parameter logic [2:0] RATE_CODE = 3'b010
) (
    input logic       clk,
    input logic       rst,
    input logic       win_end,
    input logic       auto_mode,
    input logic [2:0] rate_in,
    input logic       lock,
    input logic       sig_det,
    input logic       loop_sel,
    input logic [2:0] rate_out
);

    assert_leave_freq_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(loop_sel) |-> $past(win_end));

    assert_lock_at_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(win_end) && $past(loop_sel));

    assert_drop_at_window_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(lock) || $fell(loop_sel)) |-> $past(win_end));

    assert_rate_shown_R8: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && lock) |-> (rate_out == RATE_CODE));

    assert_manual_gate_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(auto_mode || rate_in == RATE_CODE));

    assert_detect_needs_lock_R10: assert property (@(posedge clk) disable iff (rst)
        sig_det |-> lock);

endmodule

bind rate_lock_supervisor rls_checker #(.RATE_CODE(RATE_CODE)) u_rls_checker (
    .clk      (clk_ref),
    .rst      (rst),
    .win_end  (win_end),
    .auto_mode(auto_mode),
    .rate_in  (rate_in),
    .lock     (lock_o),
    .sig_det  (sig_det_o),
    .loop_sel (loop_sel_o),
    .rate_out (rate_out)
);

// File: tb/test_rate_lock_supervisor.sv
`timescale 1ns/1ps
module test_rate_lock_supervisor;

    localparam int WIN = 1000;

    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic       rec_clk = 1'b0;
    logic       auto_mode = 1'b1;
    logic [2:0] rate_in = 3'b000;
    logic       phase_aligned = 1'b1;
    logic       lock_o, sig_det_o, loop_sel_o, rate_oe;
    logic [2:0] rate_out;

    real rec_half = 16.0;
    int  total = 0;
    int  bad = 0;
    int  edge_no = 0;
    bit  finished = 0;

    rate_lock_supervisor i_rate_lock_supervisor (
        .clk_ref      (clk_ref),
        .rst          (rst),
        .rec_clk      (rec_clk),
        .auto_mode    (auto_mode),
        .rate_in      (rate_in),
        .phase_aligned(phase_aligned),
        .lock_o       (lock_o),
        .sig_det_o    (sig_det_o),
        .loop_sel_o   (loop_sel_o),
        .rate_out     (rate_out),
        .rate_oe      (rate_oe)
    );

    always #4 clk_ref = ~clk_ref;

    // Behavioural recovered clock, offset by half a nanosecond from the grid.
    initial begin
        #0.5;
        forever #(rec_half) rec_clk = ~rec_clk;
    end

    always @(posedge clk_ref) begin
        if (rst) edge_no <= 0;
        else     edge_no <= edge_no + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk_ref);
        @(negedge clk_ref);
        rst = 1'b0;
    endtask

    // Return on the falling edge after reference edge k since reset release.
    task automatic wait_edge(input int k);
        do @(negedge clk_ref); while (edge_no < k);
    endtask

    task automatic t_reset();
        rec_half = 16.0; auto_mode = 1'b1; phase_aligned = 1'b1;
        rst = 1'b1;
        repeat (2) @(posedge clk_ref);
        @(negedge clk_ref);
        check("R1 lock in reset", int'(lock_o), 0);
        check("R1 loop_sel in reset", int'(loop_sel_o), 0);
        rst = 1'b0;
        wait_edge(1);
        check("R1 lock after reset", int'(lock_o), 0);
        check("R1 sig_det after reset", int'(sig_det_o), 0);
        check("R1 loop_sel after reset", int'(loop_sel_o), 0);
        check("R1 rate_out after reset", int'(rate_out), 0);
    endtask

    task automatic t_acquire();
        rec_half = 16.0; auto_mode = 1'b1; phase_aligned = 1'b1;
        do_reset();
        wait_edge(WIN - 1);
        check("R3 still freq acq before window end", int'(loop_sel_o), 0);
        wait_edge(WIN + 1);
        check("R3 phase acq after first window", int'(loop_sel_o), 1);
        check("R2 nominal count no early lock", int'(lock_o), 0);
        wait_edge(2 * WIN + 1);
        check("R4 one aligned window not enough", int'(lock_o), 0);
        wait_edge(3 * WIN - 1);
        check("R4 not locked before third window end", int'(lock_o), 0);
        wait_edge(3 * WIN + 1);
        check("R4 locked after two aligned windows", int'(lock_o), 1);
        check("R10 sig_det when locked auto", int'(sig_det_o), 1);
        check("R8 rate_out shows 010", int'(rate_out), 2);
        check("R8 rate_oe in auto", int'(rate_oe), 1);
    endtask

    task automatic t_unaligned();
        rec_half = 16.0; auto_mode = 1'b1; phase_aligned = 1'b0;
        do_reset();
        wait_edge(4 * WIN + 1);
        check("R5 stays in phase acq", int'(loop_sel_o), 1);
        check("R5 no lock without alignment", int'(lock_o), 0);
        phase_aligned = 1'b1;
        wait_edge(5 * WIN + 1);
        check("R5 streak restarted", int'(lock_o), 0);
        wait_edge(6 * WIN + 1);
        check("R5 lock after aligned pair", int'(lock_o), 1);
    endtask

    task automatic t_loss();
        rec_half = 16.0; auto_mode = 1'b1; phase_aligned = 1'b1;
        do_reset();
        wait_edge(3 * WIN + 1);
        check("R4 locked before loss", int'(lock_o), 1);
        rec_half = 15.0;
        wait_edge(4 * WIN - 1);
        check("R6 lock held until window end", int'(lock_o), 1);
        wait_edge(4 * WIN + 1);
        check("R6 lock dropped", int'(lock_o), 0);
        check("R6 back to freq acq", int'(loop_sel_o), 0);
        check("R10 sig_det low after loss", int'(sig_det_o), 0);
        check("R8 last rate held", int'(rate_out), 2);
    endtask

    task automatic t_fallback();
        rec_half = 16.0; auto_mode = 1'b1; phase_aligned = 1'b1;
        do_reset();
        wait_edge(WIN + 1);
        check("R3 in phase acq", int'(loop_sel_o), 1);
        rec_half = 15.0;
        wait_edge(2 * WIN + 1);
        check("R6 phase acq falls back", int'(loop_sel_o), 0);
        wait_edge(4 * WIN + 1);
        check("R6 off-rate never locks", int'(lock_o), 0);
    endtask

    task automatic t_tolerance();
        auto_mode = 1'b1; phase_aligned = 1'b1;
        rec_half = 16.2;
        do_reset();
        wait_edge(3 * WIN + 1);
        check("R2 1.2% low accepted", int'(lock_o), 1);
        rec_half = 15.6;
        do_reset();
        wait_edge(3 * WIN + 1);
        check("R2 2.6% high rejected lock", int'(lock_o), 0);
        check("R2 2.6% high rejected loop", int'(loop_sel_o), 0);
        rec_half = 16.6;
        do_reset();
        wait_edge(3 * WIN + 1);
        check("R2 3.6% low rejected", int'(loop_sel_o), 0);
    endtask

    task automatic t_harmonic();
        auto_mode = 1'b1; phase_aligned = 1'b1;
        rec_half = 8.0;
        do_reset();
        wait_edge(5 * WIN + 1);
        check("R7 double rate no lock", int'(lock_o), 0);
        check("R7 double rate freq acq", int'(loop_sel_o), 0);
        rec_half = 32.0;
        do_reset();
        wait_edge(5 * WIN + 1);
        check("R7 half rate no lock", int'(lock_o), 0);
        check("R7 half rate freq acq", int'(loop_sel_o), 0);
    endtask

    task automatic t_manual();
        rec_half = 16.0; phase_aligned = 1'b1;
        auto_mode = 1'b0; rate_in = 3'b010;
        do_reset();
        wait_edge(3 * WIN + 1);
        check("R9 manual lock at 010", int'(lock_o), 1);
        check("R9 rate_oe low", int'(rate_oe), 0);
        check("R9 rate_out zero", int'(rate_out), 0);
        check("R10 sig_det manual 010", int'(sig_det_o), 1);
        rate_in = 3'b110;
        @(negedge clk_ref);
        check("R10 sig_det drops at once", int'(sig_det_o), 0);
        check("R9 lock holds until window end", int'(lock_o), 1);
        wait_edge(4 * WIN + 1);
        check("R9 lock dropped on code change", int'(lock_o), 0);
        wait_edge(6 * WIN + 1);
        check("R9 bad code holds freq acq", int'(loop_sel_o), 0);
        rate_in = 3'b011;
        do_reset();
        wait_edge(5 * WIN + 1);
        check("R9 wrong code never locks", int'(lock_o), 0);
        check("R9 wrong code freq acq", int'(loop_sel_o), 0);
        auto_mode = 1'b1;
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_unaligned();
        t_loss();
        t_fallback();
        t_tolerance();
        t_harmonic();
        t_manual();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(180000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule